// File: doc/BRIEF.md
# Sprite Row Bitmap Generator

This block turns one moving object's three packed control words (horizontal, vertical and attribute) into a 16-row by 16-pixel foreground bitmap. After a start pulse it latches the three words and the display-mode flag, and decodes from them the card address, flips, width doubling, row count, colour, priority, displayed height and a skip flag. It then reads the card's pattern bytes from graphics memory, one byte per cycle, and reshapes each byte into a 16-bit row.

The memory port is a plain combinational read: the block drives an address with a read strobe, and the byte returned in that same cycle is used. A sprite that is off-screen or inactive is not fetched at all, and its bitmap is left all zero. All outputs hold steady from the cycle after a start is accepted until the next accepted start. Compositing the result onto the screen and detecting collisions are done elsewhere.

Top module: `sprite_row_gen`

## Requirements
- R1: `color_o` is {attr[12], attr[2:0]} and `prio_o` is attr[13], taken from the attribute word latched at the accepted start.
- R2: When xreg[10] is 1 (double width), pattern bit k drives two adjacent pixels, 2k+1 and 2k, of the 16-bit row. Bit 15 is the leftmost pixel.
- R3: When xreg[10] is 0, the reshaped byte fills row bits 15:8 and bits 7:0 are 0. When yreg[10] is 1, the byte's bit order is reversed before any doubling, so bit 0 becomes the leftmost pixel.
- R4: yreg[7] selects 16 rows instead of 8. yreg[11] flips the sprite vertically: the byte fetched for row r is written to bitmap row r XOR (rows-1). Bitmap row r occupies `bitmap_o[16r+15:16r]`.
- R5: The card base is attr[11:0] AND 0xFF8. It is further ANDed with 0x9F8 when `fgbg_i` is 1 or when bit 11 of the base is 1, and with 0xFF0 when 16 rows are used. Row r is read from base + r.
- R6: Bitmap rows from the row count up to 15 are 0.
- R7: `height_o` is looked up from yreg[9:7] as 0→8, 1→16, 2→16, 3→32, 4→32, 5→64, 6→64, 7→128.
- R8: `skip_o` is 1 when xreg[7:0] is 0, when xreg[7:0] is 167 or more, when xreg[9:8] is 00, or when 2·yreg[6:0] is 208 or more. `vis_o` is xreg[9].
- R9: A start is accepted only while the block is idle. A non-skipped sprite makes exactly one read per row, in consecutive cycles. `done_o` pulses for one cycle in the cycle after the last row is written. A skipped sprite makes no reads and pulses `done_o` two cycles after the start edge.
- R10: Between `done_o` and the next accepted start, no input other than `start_i` changes any output. After reset, `bitmap_o` is 0, `skip_o` is 1 and `done_o` and `mem_rd_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, accepted when idle |
| fgbg_i | input | 1 | Foreground/background display mode |
| xreg_i | input | 14 | Horizontal control word |
| yreg_i | input | 14 | Vertical control word |
| attr_i | input | 14 | Attribute word |
| mem_rd_o | output | 1 | Read strobe |
| mem_addr_o | output | 12 | Graphics memory address |
| mem_data_i | input | 8 | Pattern byte, valid in the cycle the address is driven |
| done_o | output | 1 | One-cycle completion pulse |
| bitmap_o | output | 256 | 16 rows of 16 pixels, row r at bits 16r+15:16r |
| color_o | output | 4 | Foreground colour |
| prio_o | output | 1 | Priority flag |
| vis_o | output | 1 | Visibility flag |
| height_o | output | 8 | Displayed height in lines |
| skip_o | output | 1 | Sprite is off-screen or inactive |

## Verification
If the row counter or the flip mask is corrupted, a whole row lands in the wrong bitmap slot. If the counter runs past its limit, rows beyond the row count come out nonzero. Either fault shows on `bitmap_o` at the `done_o` pulse of the same sprite. If the state machine gets confused, the count of `mem_rd_o` cycles comes out wrong or `done_o` moves off its fixed cycle, which is visible within about 17 cycles of the start. A decode error in the address masking shows directly on `mem_addr_o` during the fetch, and also in the bitmap contents.

// File: rtl/sprite_pkg.sv
package sprite_pkg;
  localparam int REG_W   = 14;
  localparam int MEM_AW  = 12;
  localparam int BYTE_W  = 8;
  localparam int ROWS    = 16;
  localparam int ROW_W   = 2 * BYTE_W;
  localparam int ROW_CW  = $clog2(ROWS);
  localparam int HGT_W   = 8;
  localparam int X_MAX   = 167;
  localparam int Y2_MAX  = 208;

  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_FIN} fsm_e;

  typedef struct packed {
    logic [MEM_AW-1:0] card;
    logic              res16;
    logic              vflip;
    logic              hflip;
    logic              dbl;
    logic [HGT_W-1:0]  height;
    logic              skip;
    logic [3:0]        color;
    logic              prio;
    logic              vis;
  } spr_dec_t;
endpackage

// File: rtl/sprite_decode.sv
module sprite_decode
  import sprite_pkg::*;
(
  input  logic [REG_W-1:0] xreg_i,
  input  logic [REG_W-1:0] yreg_i,
  input  logic [REG_W-1:0] attr_i,
  input  logic             fgbg_i,
  output spr_dec_t         dec_o
);
  logic [MEM_AW-1:0] card;
  logic [3:0]        hsel;
  logic [7:0]        xpos;
  logic [7:0]        ypos2;
  logic              unused_bits;

  assign unused_bits = ^{xreg_i[13:11], yreg_i[13:12]};
  assign xpos  = xreg_i[7:0];
  assign ypos2 = {yreg_i[6:0], 1'b0};
  assign hsel  = {1'b0, yreg_i[9:7]} + 4'd1;

  always_comb begin
    card = attr_i[MEM_AW-1:0] & 12'hFF8;
    if (fgbg_i || card[11]) card = card & 12'h9F8;
    if (yreg_i[7])          card = card & 12'hFF0;
  end

  always_comb begin
    dec_o        = '0;
    dec_o.card   = card;
    dec_o.res16  = yreg_i[7];
    dec_o.vflip  = yreg_i[11];
    dec_o.hflip  = yreg_i[10];
    dec_o.dbl    = xreg_i[10];
    dec_o.height = HGT_W'(8) << hsel[3:1];
    dec_o.skip   = (xpos == 8'd0) || (xpos >= 8'(X_MAX)) ||
                   (xreg_i[9:8] == 2'b00) || (ypos2 >= 8'(Y2_MAX));
    dec_o.color  = {attr_i[12], attr_i[2:0]};
    dec_o.prio   = attr_i[13];
    dec_o.vis    = xreg_i[9];
  end
endmodule

// File: rtl/sprite_row_fmt.sv
module sprite_row_fmt
  import sprite_pkg::*;
(
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              hflip_i,
  input  logic              dbl_i,
  output logic [ROW_W-1:0]  row_o
);
  logic [BYTE_W-1:0] src;
  logic [ROW_W-1:0]  wide;

  for (genvar i = 0; i < BYTE_W; i++) begin : g_bit
    assign src[i]          = hflip_i ? byte_i[BYTE_W-1-i] : byte_i[i];
    assign wide[2*i]       = src[i];
    assign wide[2*i+1]     = src[i];
  end

  assign row_o = dbl_i ? wide : {src, {BYTE_W{1'b0}}};
endmodule

// File: rtl/sprite_row_gen.sv
module sprite_row_gen
  import sprite_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic                  fgbg_i,
  input  logic [REG_W-1:0]      xreg_i,
  input  logic [REG_W-1:0]      yreg_i,
  input  logic [REG_W-1:0]      attr_i,
  output logic                  mem_rd_o,
  output logic [MEM_AW-1:0]     mem_addr_o,
  input  logic [BYTE_W-1:0]     mem_data_i,
  output logic                  done_o,
  output logic [ROWS*ROW_W-1:0] bitmap_o,
  output logic [3:0]            color_o,
  output logic                  prio_o,
  output logic                  vis_o,
  output logic [HGT_W-1:0]      height_o,
  output logic                  skip_o
);
  fsm_e                         state_q;
  logic [REG_W-1:0]             x_q, y_q, a_q;
  logic                         fgbg_q;
  logic [ROW_CW-1:0]            row_q;
  logic [ROWS-1:0][ROW_W-1:0]   bmp_q;
  spr_dec_t                     dec;
  logic [ROW_W-1:0]             row_bits;
  logic [ROW_CW-1:0]            last_row;
  logic [ROW_CW-1:0]            flip_mask;
  logic                         accept;

  sprite_decode u_dec (
    .xreg_i (x_q),
    .yreg_i (y_q),
    .attr_i (a_q),
    .fgbg_i (fgbg_q),
    .dec_o  (dec)
  );

  sprite_row_fmt u_fmt (
    .byte_i  (mem_data_i),
    .hflip_i (dec.hflip),
    .dbl_i   (dec.dbl),
    .row_o   (row_bits)
  );

  assign accept     = (state_q == ST_IDLE) && start_i;
  assign last_row   = dec.res16 ? ROW_CW'(ROWS - 1) : ROW_CW'(ROWS/2 - 1);
  assign flip_mask  = dec.vflip ? last_row : '0;
  assign mem_rd_o   = (state_q == ST_FETCH) && !dec.skip;
  assign mem_addr_o = dec.card + MEM_AW'(row_q);
  assign done_o     = (state_q == ST_FIN);
  assign bitmap_o   = bmp_q;
  assign color_o    = dec.color;
  assign prio_o     = dec.prio;
  assign vis_o      = dec.vis;
  assign height_o   = dec.height;
  assign skip_o     = dec.skip;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      x_q     <= '0;
      y_q     <= '0;
      a_q     <= '0;
      fgbg_q  <= 1'b0;
      row_q   <= '0;
      bmp_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          x_q     <= xreg_i;
          y_q     <= yreg_i;
          a_q     <= attr_i;
          fgbg_q  <= fgbg_i;
          row_q   <= '0;
          bmp_q   <= '0;
          state_q <= ST_FETCH;
        end
        ST_FETCH: begin
          if (dec.skip) begin
            state_q <= ST_FIN;
          end else begin
            bmp_q[row_q ^ flip_mask] <= row_bits;
            if (row_q == last_row) begin
              row_q   <= '0;
              state_q <= ST_FIN;
            end else begin
              row_q <= row_q + 1'b1;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  a_r9_done_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r9_done_follows_fetch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !skip_o) |-> $past(mem_rd_o));

  a_r9_skip_no_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && skip_o) |-> !$past(mem_rd_o));

  a_r10_hold_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && !start_i) |=> ($stable(bitmap_o) && $stable(color_o) &&
                                          $stable(skip_o) && $stable(height_o)));

  a_r6_upper_rows_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !y_q[7]) |-> (bitmap_o[ROWS*ROW_W-1:ROWS*ROW_W/2] == '0));

  a_r5_mode_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rd_o && fgbg_q) |-> (mem_addr_o[10:9] == 2'b00));
endmodule

// File: tb/sprite_row_gen_tb_top.sv
module sprite_row_gen_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic         fgbg = 1'b0;
  logic [13:0]  xreg = '0, yreg = '0, attr = '0;
  logic         mem_rd;
  logic [11:0]  mem_addr;
  logic [7:0]   mem_data;
  logic         done;
  logic [255:0] bitmap;
  logic [3:0]   color;
  logic         prio, vis, skip;
  logic [7:0]   height;
  int           n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  function automatic logic [7:0] pat(input logic [11:0] a);
    return (a[7:0] * 8'd37 + 8'd11) ^ {a[11:8], a[11:8]};
  endfunction
  assign mem_data = pat(mem_addr);

  sprite_row_gen dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .fgbg_i(fgbg),
    .xreg_i(xreg), .yreg_i(yreg), .attr_i(attr),
    .mem_rd_o(mem_rd), .mem_addr_o(mem_addr), .mem_data_i(mem_data),
    .done_o(done), .bitmap_o(bitmap), .color_o(color), .prio_o(prio),
    .vis_o(vis), .height_o(height), .skip_o(skip)
  );

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  task automatic check(input string req, input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_row(input logic [7:0] d, input logic hf, input logic dw);
    logic [15:0] r = '0;
    for (int p = 0; p < 16; p++) begin
      int k;
      if (dw) k = p / 2; else k = p;
      if (k < 8) r[15-p] = hf ? d[k] : d[7-k];
    end
    return r;
  endfunction

  function automatic logic [11:0] exp_card(input logic [13:0] a, input logic [13:0] y, input logic m);
    logic [11:0] c = a[11:0] & 12'hFF8;
    if (m || c[11]) c &= 12'h9F8;
    if (y[7]) c &= 12'hFF0;
    return c;
  endfunction

  function automatic logic exp_skip(input logic [13:0] x, input logic [13:0] y);
    return (x[7:0] == 0) || (x[7:0] >= 167) || (x[9:8] == 0) || ((int'(y[6:0]) * 2) >= 208);
  endfunction

  function automatic logic [7:0] exp_hgt(input logic [2:0] s);
    case (s)
      3'd0: return 8;    3'd1, 3'd2: return 16;
      3'd3, 3'd4: return 32; 3'd5, 3'd6: return 64;
      default: return 128;
    endcase
  endfunction

  // starts a sprite, counts reads until done, checks every output
  task automatic run(input logic [13:0] x, input logic [13:0] y, input logic [13:0] a,
                     input logic m, input string tag);
    int reads = 0, wait_c = 0, rows;
    logic sk;
    logic [11:0] c;
    logic [255:0] eb = '0;
    @(negedge clk);
    xreg = x; yreg = y; attr = a; fgbg = m; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done && wait_c < 40) begin
      if (mem_rd) reads++;
      wait_c++;
      @(negedge clk);
    end
    sk = exp_skip(x, y);
    rows = y[7] ? 16 : 8;
    c = exp_card(a, y, m);
    if (!sk)
      for (int r = 0; r < rows; r++) begin
        int src = y[11] ? (r ^ (rows - 1)) : r;
        eb[16*r +: 16] = exp_row(pat(c + 12'(src)), y[10], x[10]);
      end
    check({tag, " R8 skip"}, 256'(skip), 256'(sk));
    check({tag, " R8 vis"}, 256'(vis), 256'(x[9]));
    check({tag, " R1 color/prio"}, 256'({prio, color}), 256'({a[13], a[12], a[2:0]}));
    check({tag, " R7 height"}, 256'(height), 256'(exp_hgt(y[9:7])));
    check({tag, " R9 read count"}, 256'(reads), 256'(sk ? 0 : rows));
    check({tag, " R9 done latency"}, 256'(wait_c), 256'(sk ? 1 : rows));
    check({tag, " R2 R3 R4 R5 R6 bitmap"}, bitmap, eb);
    @(negedge clk);
    check({tag, " R9 done pulse width"}, 256'(done), 256'(0));
  endtask

  task automatic t_reset();
    check("R10 reset bitmap", bitmap, '0);
    check("R10 reset skip", 256'(skip), 256'(1));
    check("R10 reset done/rd", 256'({done, mem_rd}), 256'(0));
  endtask

  task automatic t_hold();
    logic [255:0] b0 = bitmap;
    logic [3:0]   c0 = color;
    @(negedge clk);
    xreg = 14'h3FFF; yreg = 14'h0123; attr = 14'h1555; fgbg = ~fgbg;
    repeat (4) @(negedge clk);
    check("R10 bitmap held", bitmap, b0);
    check("R10 color held", 256'(color), 256'(c0));
    check("R10 no read when idle", 256'(mem_rd), 256'(0));
  endtask

  task automatic t_start_while_busy();
    @(negedge clk);
    xreg = 14'h0250; yreg = 14'h0010; attr = 14'h0108; fgbg = 0; start = 1;
    @(negedge clk);
    attr = 14'h0FF8; xreg = 14'h0000;
    repeat (3) @(negedge clk);
    start = 0;
    while (!done) @(negedge clk);
    check("R9 start ignored while busy skip", 256'(skip), 256'(0));
    check("R9 start ignored while busy bitmap row0", 256'(bitmap[15:0]),
          256'(exp_row(pat(12'h108), 1'b0, 1'b0)));
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    run(14'h0250, 14'h0010, 14'h0108, 0, "plain");
    run(14'h0650, 14'h0010, 14'h1234, 0, "double");
    run(14'h0250, 14'h0410, 14'h2207, 0, "hflip");
    run(14'h0650, 14'h0410, 14'h3ABC, 0, "hflip+double");
    run(14'h0350, 14'h0890, 14'h0F48, 0, "16row vflip");
    run(14'h0150, 14'h0810, 14'h0678, 0, "8row vflip");
    run(14'h0250, 14'h0010, 14'h0678, 1, "R5 fgbg mask");
    run(14'h0250, 14'h0090, 14'h0E78, 0, "R5 bit11 mask 16row");
    run(14'h0250, 14'h0010, 14'h0678, 0, "R5 no mask");
    run(14'h0200, 14'h0010, 14'h0100, 0, "R8 x=0");
    run(14'h02A7, 14'h0010, 14'h0100, 0, "R8 x=167");
    run(14'h02A6, 14'h0010, 14'h0100, 0, "R8 x=166");
    run(14'h0050, 14'h0010, 14'h0100, 0, "R8 inactive");
    run(14'h0150, 14'h0068, 14'h0100, 0, "R8 y=104");
    run(14'h0150, 14'h0067, 14'h0100, 0, "R8 y=103");
    for (int s = 0; s < 8; s++)
      run(14'h0250, 14'(s << 7), 14'h0200, 0, "R7 height sel");
    t_hold();
    t_start_while_busy();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule